// File: doc/BRIEF.md
# Embedded-Sync Video Stream Decoder

This block recovers video timing from an 8-bit 4:2:2 standard-definition byte stream in which the synchronisation information travels inside the data. The stream carries no separate sync pins. The block watches for the three-byte preamble 0xFF 0x00 0x00. It takes the byte that follows as a status byte, checks that byte's protection bits, and from it maintains field, vertical-blanking and horizontal-blanking outputs.

After a start-of-active-video code on an active (non-blanking) line, the block passes the following bytes out with a data-enable. Each passed byte carries its index within the line. The block also keeps a count of the active lines seen in the current field. A status byte that fails its protection check raises a one-cycle error pulse and changes nothing else. Colour conversion, chroma upsampling and frame storage belong to downstream blocks.

The input is qualified by a valid strobe and has no ready signal. A video source is byte-locked and cannot be stalled, so the block accepts every byte presented with `in_valid` high. Cycles with `in_valid` low are gaps that the block ignores entirely. The output side also has no back-pressure: `act_valid` is a one-cycle qualifier that downstream logic must capture on the cycle it appears.

Top module: `embsync_decoder`

## Requirements
- R1: After reset, `act_valid`, `code_err` and `line_no` are 0, `fld` is 0, and `vblank` and `hblank` are 1.
- R2: A timing code is the accepted byte sequence 0xFF, 0x00, 0x00, S. The status byte S is laid out as follows: bit 7 must be 1, bit 6 is F (0 top field, 1 bottom field), bit 5 is V (1 blanking line), and bit 4 is H (0 start code, 1 end code). Bits 3..0 must equal V^H, F^H, F^V and F^V^H. When S is valid, `fld`, `vblank` and `hblank` take F, V and H in the cycle after S is accepted.
- R3: When S has bit 7 clear or any protection bit wrong, `code_err` is 1 for exactly the cycle after S. In that case the flags, the line count and the enable state are left unchanged, and S itself is not output as data.
- R4: After a valid start code with V=0, each following accepted byte appears on `act_data` with `act_valid` high in the cycle after it is accepted. Its `act_idx` counts 0, 1, 2 and so on.
- R5: At most LINE_BYTES bytes (1440 by default) are enabled after one start code. Further bytes are not output.
- R6: A valid end code stops the enable. Its status byte and all bytes after it are not output. Because the block has no lookahead, the three preamble bytes of an end code that arrives inside the active run are still output as data.
- R7: A valid start code with V=1 enables no bytes.
- R8: On a valid status byte, `line_no` becomes 0 if F differs from `fld` or if V is 1 while `vblank` is 0. Otherwise it increments on a start code with V=0. The new value is seen in the cycle after the status byte, and the reset condition takes priority over the increment.
- R9: Any byte that does not continue the preamble restarts the search, and a 0xFF always begins a new preamble. As a result, 0xFF inside data cannot hide or fake a code, and 0xFF 0xFF 0x00 0x00 S is still recognised.
- R10: A cycle with `in_valid` low is ignored: no output is enabled for it and no search, flag or count state changes, even in the middle of a preamble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte qualifier |
| in_data | input | 8 | Input stream byte |
| fld | output | 1 | Current field flag F |
| vblank | output | 1 | Current vertical-blanking flag V |
| hblank | output | 1 | H flag of the last valid code (1 after an end code) |
| code_err | output | 1 | One-cycle pulse for a corrupt status byte |
| act_valid | output | 1 | Active-data enable |
| act_data | output | 8 | Active data byte |
| act_idx | output | $clog2(LINE_BYTES) | Byte index of `act_data` within the active line |
| line_no | output | LINE_W | Active-line count within the field |

## Verification
A search machine that has slipped out of step would show at the ports within one line. Either a real start code would go missing, so no `act_valid` follows it, or stray flag changes would appear after a data byte of 0xFF. A corrupt enable counter shows as a break in the `act_idx` sequence or as bytes enabled past the cap. A wrong protection check shows at the very next status byte, either as a spurious `code_err` or as flags that move when they should hold. The bench replays random lines with gaps, early and late end codes, and field and blanking changes. It compares every output on every byte against a model built from the requirements, so any divergence is reported on the cycle it appears.

// File: rtl/vsd_pkg.sv
package vsd_pkg;

  typedef struct packed {
    logic f;
    logic v;
    logic h;
  } tflags_t;

  typedef enum logic [1:0] {
    S_HUNT = 2'd0,
    S_FF   = 2'd1,
    S_Z1   = 2'd2,
    S_Z2   = 2'd3
  } srch_t;

  localparam logic [7:0] PRE_LEAD = 8'hFF;
  localparam logic [7:0] PRE_ZERO = 8'h00;

  // Protection check of a status byte: marker bit plus four parity bits.
  function automatic logic status_ok(input logic [7:0] b);
    logic f, v, h;
    f = b[6];
    v = b[5];
    h = b[4];
    return b[7] && (b[3] == (v ^ h)) && (b[2] == (f ^ h)) &&
           (b[1] == (f ^ v)) && (b[0] == (f ^ v ^ h));
  endfunction

  function automatic tflags_t status_flags(input logic [7:0] b);
    tflags_t t;
    t.f = b[6];
    t.v = b[5];
    t.h = b[4];
    return t;
  endfunction

endpackage

// File: rtl/vsd_trs_finder.sv
module vsd_trs_finder
  import vsd_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  output logic          hit,
  output logic          hit_ok,
  output tflags_t       hit_flags
);

  srch_t state, state_nx;

  // The status byte is decoded in the same cycle it is accepted.
  assign hit       = in_valid && (state == S_Z2);
  assign hit_ok    = status_ok(in_data);
  assign hit_flags = status_flags(in_data);

  always_comb begin
    state_nx = state;
    if (in_valid) begin
      if (in_data == PRE_LEAD) begin
        state_nx = S_FF;
      end else begin
        unique case (state)
          S_FF:    state_nx = (in_data == PRE_ZERO) ? S_Z1 : S_HUNT;
          S_Z1:    state_nx = (in_data == PRE_ZERO) ? S_Z2 : S_HUNT;
          default: state_nx = S_HUNT;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_HUNT;
    else        state <= state_nx;
  end

  AST_LEAD_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_data == PRE_LEAD) |=> (state == S_FF)); // R9

  AST_STRAY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_data != PRE_LEAD && in_data != PRE_ZERO) |=> (state == S_HUNT)); // R9

  AST_GAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid) |=> $stable(state)); // R10

endmodule

// File: rtl/vsd_active_gate.sv
module vsd_active_gate
  import vsd_pkg::*;
#(
  parameter  int LINE_BYTES = 1440,
  localparam int IDX_W      = $clog2(LINE_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             hit,
  input  logic             hit_ok,
  input  tflags_t          hit_flags,
  output logic             act_valid,
  output logic [7:0]       act_data,
  output logic [IDX_W-1:0] act_idx
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINE_BYTES - 1);

  logic             armed;
  logic [IDX_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      cnt       <= '0;
      act_valid <= 1'b0;
      act_data  <= '0;
      act_idx   <= '0;
    end else begin
      act_valid <= 1'b0;
      if (in_valid) begin
        if (hit) begin
          if (hit_ok) begin
            armed <= !hit_flags.v && !hit_flags.h;
            cnt   <= '0;
          end
        end else if (armed) begin
          act_valid <= 1'b1;
          act_data  <= in_data;
          act_idx   <= cnt;
          if (cnt == LAST_IDX) armed <= 1'b0;
          else                 cnt   <= cnt + 1'b1;
        end
      end
    end
  end

  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid |-> (act_idx <= LAST_IDX)); // R5

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && $past(act_valid)) |-> (act_idx == 0 || act_idx == $past(act_idx) + IDX_W'(1))); // R4

  AST_STATUS_NOT_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !act_valid); // R6

endmodule

// File: rtl/vsd_line_track.sv
module vsd_line_track
  import vsd_pkg::*;
#(
  parameter int LINE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  tflags_t           new_flags,
  input  tflags_t           cur_flags,
  output logic [LINE_W-1:0] line_no
);

  logic restart;
  assign restart = (new_flags.f != cur_flags.f) || (new_flags.v && !cur_flags.v);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_no <= '0;
    end else if (take) begin
      if (restart)                           line_no <= '0;
      else if (!new_flags.v && !new_flags.h) line_no <= line_no + 1'b1;
    end
  end

  AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (line_no != $past(line_no)) |-> (line_no == '0 || line_no == $past(line_no) + LINE_W'(1))); // R8

  AST_LINE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(line_no)); // R3

endmodule

// File: rtl/embsync_decoder.sv
module embsync_decoder
  import vsd_pkg::*;
#(
  parameter  int LINE_BYTES = 1440,
  parameter  int LINE_W     = 10,
  localparam int IDX_W      = $clog2(LINE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              fld,
  output logic              vblank,
  output logic              hblank,
  output logic              code_err,
  output logic              act_valid,
  output logic [7:0]        act_data,
  output logic [IDX_W-1:0]  act_idx,
  output logic [LINE_W-1:0] line_no
);

  logic    hit, hit_ok;
  tflags_t hit_flags, cur_flags;

  vsd_trs_finder u_finder (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .hit       (hit),
    .hit_ok    (hit_ok),
    .hit_flags (hit_flags)
  );

  // Flag register: only a status byte that passes its check is applied.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_flags <= '{f: 1'b0, v: 1'b1, h: 1'b1};
      code_err  <= 1'b0;
    end else begin
      code_err <= hit && !hit_ok;
      if (hit && hit_ok) cur_flags <= hit_flags;
    end
  end

  assign fld    = cur_flags.f;
  assign vblank = cur_flags.v;
  assign hblank = cur_flags.h;

  vsd_active_gate #(.LINE_BYTES(LINE_BYTES)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .hit       (hit),
    .hit_ok    (hit_ok),
    .hit_flags (hit_flags),
    .act_valid (act_valid),
    .act_data  (act_data),
    .act_idx   (act_idx)
  );

  vsd_line_track #(.LINE_W(LINE_W)) u_lines (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (hit && hit_ok),
    .new_flags (hit_flags),
    .cur_flags (cur_flags),
    .line_no   (line_no)
  );

  AST_ERR_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    code_err |-> $stable({fld, vblank, hblank})); // R3

  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    code_err |=> !code_err); // R3

  AST_NO_EN_IN_VBLANK: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid |-> !vblank); // R7

endmodule

// File: tb/embsync_decoder_test.sv
module embsync_decoder_test;

  localparam int LB = 1440;
  localparam int IW = $clog2(LB);
  localparam int LW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [7:0]    in_data = 8'h00;
  logic          fld, vblank, hblank, code_err, act_valid;
  logic [7:0]    act_data;
  logic [IW-1:0] act_idx;
  logic [LW-1:0] line_no;

  embsync_decoder #(.LINE_BYTES(LB), .LINE_W(LW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .fld(fld), .vblank(vblank), .hblank(hblank), .code_err(code_err),
    .act_valid(act_valid), .act_data(act_data), .act_idx(act_idx), .line_no(line_no)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Model state derived from the requirements.
  bit m_f = 0, m_v = 1, m_h = 1, m_act = 0;
  int m_idx = 0, m_line = 0;

  function automatic logic [7:0] mk(input bit f, input bit v, input bit h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // kind: 0 ordinary byte, 1 valid status byte, 2 corrupt status byte.
  task automatic step(input bit vld, input logic [7:0] b, input int kind, input string tag);
    bit e_valid = 0, e_err = 0;
    int e_data = 0, e_idx = 0;
    in_valid = vld;
    in_data  = b;
    if (vld) begin
      if (kind == 0) begin
        if (m_act) begin
          e_valid = 1; e_data = b; e_idx = m_idx;
          if (m_idx == LB - 1) m_act = 0; else m_idx++;
        end
      end else if (kind == 1) begin
        if (b[6] != m_f || (b[5] && !m_v)) m_line = 0;
        else if (!b[5] && !b[4]) m_line = (m_line + 1) % (1 << LW);
        m_f = b[6]; m_v = b[5]; m_h = b[4];
        m_act = !b[5] && !b[4];
        m_idx = 0;
      end else begin
        e_err = 1;
      end
    end
    @(negedge clk);
    chk(act_valid == e_valid, tag, "act_valid", act_valid, e_valid);
    if (e_valid && act_valid) begin
      chk(act_data == e_data, "R4", "act_data", act_data, e_data);
      chk(act_idx == e_idx, "R4", "act_idx", act_idx, e_idx);
    end
    chk(code_err == e_err, "R3", "code_err", code_err, e_err);
    chk({fld, vblank, hblank} == {m_f, m_v, m_h}, "R2", "flags", {fld, vblank, hblank}, {m_f, m_v, m_h});
    chk(line_no == m_line, "R8", "line_no", line_no, m_line);
  endtask

  task automatic code(input bit f, input bit v, input bit h, input string tag);
    step(1, 8'hFF, 0, tag);
    step(1, 8'h00, 0, tag);
    step(1, 8'h00, 0, tag);
    step(1, mk(f, v, h), 1, tag);
  endtask

  task automatic bad_code(input logic [7:0] s, input string tag);
    step(1, 8'hFF, 0, tag);
    step(1, 8'h00, 0, tag);
    step(1, 8'h00, 0, tag);
    step(1, s, 2, tag);
  endtask

  // Data bytes exclude 0x00, so no preamble can form; gaps carry arbitrary bytes.
  task automatic bytes(input int n, input int gap_pct, input string tag);
    for (int i = 0; i < n; i++) begin
      if ($urandom_range(99, 0) < gap_pct) step(0, 8'($urandom_range(255, 0)), 0, "R10");
      step(1, 8'($urandom_range(255, 1)), 0, tag);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(act_valid == 0, "R1", "act_valid", act_valid, 0);
    chk(code_err == 0, "R1", "code_err", code_err, 0);
    chk({fld, vblank, hblank} == 3'b011, "R1", "flags", {fld, vblank, hblank}, 3'b011);
    chk(line_no == 0, "R1", "line_no", line_no, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2, R7: blanking line with a start code that has V=1
    code(0, 1, 1, "R2");
    bytes(280, 0, "R2");
    code(0, 1, 0, "R7");
    bytes(40, 0, "R7");
    // V falls on the end code, then a full active line (R4, R8)
    code(0, 0, 1, "R2");
    bytes(280, 0, "R2");
    code(0, 0, 0, "R8");
    bytes(LB, 0, "R4");
    // R5: overlong active run
    code(0, 0, 1, "R5");
    bytes(280, 0, "R5");
    code(0, 0, 0, "R5");
    bytes(LB + 9, 0, "R5");
    // R6: early end code inside the active run
    code(0, 0, 0, "R6");
    bytes(100, 0, "R6");
    code(0, 0, 1, "R6");
    bytes(30, 0, "R6");
    // R9: FF inside data, then a doubled lead byte before a start code
    code(0, 0, 0, "R9");
    step(1, 8'hFF, 0, "R9");
    step(1, 8'h55, 0, "R9");
    step(1, 8'hFF, 0, "R9");
    step(1, 8'hFF, 0, "R9");
    step(1, 8'h00, 0, "R9");
    step(1, 8'h00, 0, "R9");
    step(1, mk(0, 0, 1), 1, "R9");
    step(1, 8'hFF, 0, "R9");
    step(1, 8'hFF, 0, "R9");
    step(1, 8'h00, 0, "R9");
    step(1, 8'h00, 0, "R9");
    step(1, mk(0, 0, 0), 1, "R9");
    bytes(20, 0, "R9");
    // R3: corrupt status bytes inside active data and during blanking
    bad_code(mk(0, 0, 1) ^ 8'h01, "R3");
    bytes(20, 0, "R3");
    code(0, 0, 1, "R3");
    bad_code(mk(1, 1, 0) & 8'h7F, "R3");
    bad_code(mk(0, 0, 0) ^ 8'h08, "R3");
    bytes(10, 0, "R3");
    // R10: gaps inside a preamble carrying preamble-like bytes
    step(1, 8'hFF, 0, "R10");
    step(0, 8'h00, 0, "R10");
    step(1, 8'h00, 0, "R10");
    step(0, 8'hFF, 0, "R10");
    step(1, 8'h00, 0, "R10");
    step(0, 8'h00, 0, "R10");
    step(1, mk(0, 0, 0), 1, "R10");
    bytes(200, 30, "R10");
    // R8: V rising resets the count, F change with a start code resets too
    code(0, 1, 1, "R8");
    code(1, 0, 0, "R8");
    bytes(50, 0, "R8");

    // Random lines
    for (int ln = 0; ln < 24; ln++) begin
      bit f = m_f, v = m_v;
      int sel = $urandom_range(9, 0);
      if (sel == 0) f = !f;
      if (sel == 1) v = 1;
      if (sel >= 7) v = 0;
      code(f, v, 1, "R2");
      bytes($urandom_range(300, 50), 10, "R2");
      if ($urandom_range(9, 0) == 0) bad_code(mk(f, v, 0) ^ 8'($urandom_range(15, 1)), "R3");
      code(f, v, 0, "R4");
      case ($urandom_range(2, 0))
        0: bytes(LB, 5, "R4");
        1: bytes($urandom_range(LB - 1, 1), 5, "R6");
        default: bytes(LB + $urandom_range(8, 1), 5, "R5");
      endcase
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule